// File: doc/BRIEF.md
# Multi-Source Timer Counter Bank

This block is a bank of identical 16-bit timer channels reached through one byte-wide register port. Each channel counts a prescaled version of the system clock. It compares the count against four compare registers and raises flags when they match. Any one of those compare registers can be chosen to reset the count, which gives a periodic counter. Each channel drives two compare output pins, and each pin follows a coded action when its compare register matches. Each channel also has one interrupt line, built from its flags and the flags' enable bits.

A shared start register holds one run bit per channel. A channel counts only while its bit is set. Only plain up-counting is provided. Software normally stops a channel, loads the counter and the compare registers, selects the prescaler and the clear source, and then sets the channel's run bit. Status flags are cleared by a read of the status byte followed by a write of zero to the flag.

Top module: `cmt_timer_bank`

## Requirements
- R1: After reset every channel register, the start register, every compare pin and every interrupt line read 0.
- R2: The start register sits at byte address NCH*16 (0x30 by default), and bit n of it runs channel n. A channel's counter changes only while its bit is 1. The other channels' bits have no effect on it, and the start register reads back as written.
- R3: Control bits 2:0 pick the count rate. Code 0 ticks on every clock, and codes 1, 2 and 3 tick on every 4th, 16th and 64th clock of running time. Codes 4 to 7 produce no ticks, so the counter holds.
- R4: Control bits 7:5 pick the clear source. Code 1 clears on compare A, code 2 on B, code 5 on C and code 6 on D. On a tick where the counter equals the selected compare value, the next count is 0, so the period is value+1 ticks. Codes 0, 3, 4 and 7 never clear the counter.
- R5: On a tick that takes the counter from 0xFFFF to 0 with no clear, status bit 4 (overflow) is set.
- R6: On a tick where the counter equals compare A, B, C or D, status bit 0, 1, 2 or 3 is set, respectively.
- R7: A status bit is cleared only by a write of 0 to it that follows a read of the status byte in which the bit was 1. Writing 1, or writing 0 with no such read, leaves the bit set.
- R8: The byte at offset 2 holds two 4-bit pin codes: the low nibble drives pin A, which matches compare A, and the high nibble drives pin B, which matches compare B. Writing code 1, 2 or 3 forces the pin to 0, and code 5, 6 or 7 forces it to 1. On a match, codes 1 and 5 clear the pin, 2 and 6 set it, and 3 and 7 toggle it. Any other code leaves the pin unchanged.
- R9: Interrupt-enable bits 0 to 5 gate status bits 0 to 5. The interrupt line is the registered OR of the enabled flags, so it rises one clock after an enabled flag is set, and it stays low while every flag is masked.
- R10: Within a channel's 16-byte window the offsets are: control 0, mode 1, pin codes 2, interrupt enable 4, status 5, counter high byte 6 and low byte 7. Compares A, B, C and D sit at offsets 8, 10, 12 and 14, with the high byte first. Counter writes take effect only while the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe; data appears on rdata one clock later |
| addr | input | ADDR_W | Byte address (channel n at n*16, start register at NCH*16) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| irq | output | NCH | One interrupt line per channel |
| cmp_pin | output | 2*NCH | Compare pins; bit 2n is pin A of channel n and bit 2n+1 is pin B |

## Verification
The bench builds the bank with its defaults: three channels and a 6-bit address. With three channels, running one channel while another holds a preloaded count shows that the start bits are independent. The slowest prescaler code completes two ticks within about 130 clocks, so every rate code is observed. Counter wrap-around is reached by preloading 0xFFFE, rather than by counting through the full 16-bit range.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int CNT_W  = 16;
  localparam int NCMP   = 4;
  localparam int FLAG_W = 6;
  localparam int WIN_W  = 4;

  localparam logic [3:0] OFF_CTRL  = 4'd0;
  localparam logic [3:0] OFF_MODE  = 4'd1;
  localparam logic [3:0] OFF_PINS  = 4'd2;
  localparam logic [3:0] OFF_IEN   = 4'd4;
  localparam logic [3:0] OFF_STAT  = 4'd5;
  localparam logic [3:0] OFF_CNT_H = 4'd6;
  localparam logic [3:0] OFF_CNT_L = 4'd7;
  localparam logic [3:0] OFF_CMP   = 4'd8;

  typedef struct packed {
    logic [2:0] clr_src;
    logic [1:0] edge_mode;
    logic [2:0] rate;
  } ctrl_t;

  function automatic logic clear_hit(input logic [2:0] src, input logic [NCMP-1:0] hit);
    case (src)
      3'd1:    clear_hit = hit[0];
      3'd2:    clear_hit = hit[1];
      3'd5:    clear_hit = hit[2];
      3'd6:    clear_hit = hit[3];
      default: clear_hit = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler #(
  parameter int DIV_W = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [2:0] rate,
  output logic       tick
);
  localparam int NSTAGE = 4;

  logic [DIV_W-1:0]  div_q;
  logic [NSTAGE-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst || !run) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    if (k == 0) begin : g_every
      assign stage[k] = 1'b1;
    end else begin : g_div
      assign stage[k] = &div_q[2*k-1:0];
    end
  end

  assign tick = run && !rate[2] && stage[rate[1:0]];
endmodule

// File: rtl/cmt_pin_action.sv
module cmt_pin_action (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [3:0] new_code,
  input  logic       hit,
  output logic [3:0] code,
  output logic       pin
);
  logic [3:0] code_q;
  logic       pin_q;

  function automatic logic active(input logic [3:0] c);
    active = !c[3] && (c[1:0] != 2'd0);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      pin_q  <= 1'b0;
    end else if (load) begin
      code_q <= new_code;
      if (active(new_code)) pin_q <= new_code[2];
    end else if (hit && active(code_q)) begin
      case (code_q[1:0])
        2'd1:    pin_q <= 1'b0;
        2'd2:    pin_q <= 1'b1;
        default: pin_q <= ~pin_q;
      endcase
    end
  end

  assign code = code_q;
  assign pin  = pin_q;
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wr,
  input  logic              rd,
  input  logic [WIN_W-1:0]  off,
  input  logic [7:0]        wdata,
  output logic [7:0]        rbyte,
  output logic              irq,
  output logic [1:0]        pins,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [2:0]        rate_o,
  output logic [FLAG_W-1:0] stat_o
);
  ctrl_t                           ctrl_q;
  logic [3:0]                      mode_q;
  logic [FLAG_W-1:0]               ien_q, stat_q, arm_q;
  logic [FLAG_W-1:0]               set_v, clr_v;
  logic [CNT_W-1:0]                cnt_q;
  logic [NCMP-1:0][CNT_W-1:0]      cmp_q;
  logic [NCMP-1:0]                 hit;
  logic                            tick, wrap_clr, ovf, irq_q;
  logic [7:0]                      pin_codes;
  logic                            stat_wr, stat_rd;

  cmt_prescaler #(.DIV_W(DIV_W)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .rate (ctrl_q.rate),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mode_q <= '0;
      ien_q  <= '0;
    end else if (wr) begin
      case (off)
        OFF_CTRL: ctrl_q <= ctrl_t'(wdata);
        OFF_MODE: mode_q <= wdata[3:0];
        OFF_IEN:  ien_q  <= wdata[FLAG_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
    end else if (wr && off[3]) begin
      for (int k = 0; k < NCMP; k++) begin
        if (off[2:1] == 2'(k)) begin
          if (off[0]) cmp_q[k][7:0]       <= wdata;
          else        cmp_q[k][CNT_W-1:8] <= wdata;
        end
      end
    end
  end

  for (genvar k = 0; k < NCMP; k++) begin : g_hit
    assign hit[k] = tick && (cnt_q == cmp_q[k]);
  end

  assign wrap_clr = clear_hit(ctrl_q.clr_src, hit);
  assign ovf      = tick && !wrap_clr && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= wrap_clr ? '0 : cnt_q + 1'b1;
    end else if (wr && !run) begin
      if (off == OFF_CNT_H)      cnt_q[CNT_W-1:8] <= wdata;
      else if (off == OFF_CNT_L) cnt_q[7:0]       <= wdata;
    end
  end

  assign stat_wr = wr && (off == OFF_STAT);
  assign stat_rd = rd && (off == OFF_STAT);
  assign set_v   = {1'b0, ovf, hit};
  assign clr_v   = stat_wr ? (arm_q & ~wdata[FLAG_W-1:0]) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      arm_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_v) | set_v;
      arm_q  <= (arm_q & ~clr_v) | (stat_rd ? stat_q : '0);
      irq_q  <= |(stat_q & ien_q);
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_pin
    cmt_pin_action u_pin (
      .clk      (clk),
      .rst      (rst),
      .load     (wr && (off == OFF_PINS)),
      .new_code (wdata[4*p+3:4*p]),
      .hit      (hit[p]),
      .code     (pin_codes[4*p+3:4*p]),
      .pin      (pins[p])
    );
  end

  always_comb begin
    rbyte = '0;
    if (off[3]) begin
      rbyte = off[0] ? cmp_q[off[2:1]][7:0] : cmp_q[off[2:1]][CNT_W-1:8];
    end else begin
      case (off)
        OFF_CTRL:  rbyte = ctrl_q;
        OFF_MODE:  rbyte = {4'b0, mode_q};
        OFF_PINS:  rbyte = pin_codes;
        OFF_IEN:   rbyte = 8'(ien_q);
        OFF_STAT:  rbyte = 8'(stat_q);
        OFF_CNT_H: rbyte = cnt_q[CNT_W-1:8];
        OFF_CNT_L: rbyte = cnt_q[7:0];
        default:   rbyte = '0;
      endcase
    end
  end

  assign irq    = irq_q;
  assign cnt_o  = cnt_q;
  assign rate_o = ctrl_q.rate;
  assign stat_o = stat_q;
endmodule

// File: rtl/cmt_timer_bank.sv
module cmt_timer_bank
  import cmt_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int ADDR_W = 6,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [NCH-1:0]    irq,
  output logic [2*NCH-1:0]  cmp_pin
);
  localparam int               SEL_W      = ADDR_W - WIN_W;
  localparam logic [ADDR_W-1:0] START_ADDR = ADDR_W'(NCH << WIN_W);

  logic [NCH-1:0]              run_q;
  logic [NCH-1:0][7:0]         rbyte_v;
  logic [NCH-1:0][CNT_W-1:0]   cnt_vec;
  logic [NCH-1:0][2:0]         rate_vec;
  logic [NCH-1:0][FLAG_W-1:0]  stat_vec;
  logic [7:0]                  rsel, rdata_q;

  always_ff @(posedge clk) begin
    if (rst)                               run_q <= '0;
    else if (wr_en && addr == START_ADDR)  run_q <= wdata[NCH-1:0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit_win;
    assign hit_win = (addr[ADDR_W-1:WIN_W] == SEL_W'(i));

    cmt_channel #(.DIV_W(DIV_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .run    (run_q[i]),
      .wr     (wr_en && hit_win),
      .rd     (rd_en && hit_win),
      .off    (addr[WIN_W-1:0]),
      .wdata  (wdata),
      .rbyte  (rbyte_v[i]),
      .irq    (irq[i]),
      .pins   (cmp_pin[2*i+1:2*i]),
      .cnt_o  (cnt_vec[i]),
      .rate_o (rate_vec[i]),
      .stat_o (stat_vec[i])
    );
  end

  always_comb begin
    rsel = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr[ADDR_W-1:WIN_W] == SEL_W'(i)) rsel = rbyte_v[i];
    end
    if (addr == START_ADDR) rsel = 8'(run_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rsel;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/cmt_timer_bank_chk.sv
module cmt_timer_bank_chk
  import cmt_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int ADDR_W = 6
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             wr_en,
  input logic [ADDR_W-1:0]                addr,
  input logic [NCH-1:0]                   run_q,
  input logic [NCH-1:0]                   irq,
  input logic [NCH-1:0][CNT_W-1:0]        cnt_vec,
  input logic [NCH-1:0][2:0]              rate_vec,
  input logic [NCH-1:0][FLAG_W-1:0]       stat_vec
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    ($past(rst) && !rst) |-> (run_q == '0 && irq == '0)); // R1

  for (genvar i = 0; i < NCH; i++) begin : g_c
    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
      ($past(!run_q[i]) && $past(!wr_en)) |-> $stable(cnt_vec[i])); // R2

    AST_RESERVED_RATE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (run_q[i] && rate_vec[i][2]) |=> $stable(cnt_vec[i])); // R3

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[i]) |-> $past(stat_vec[i] != '0)); // R9

    for (genvar k = 0; k < FLAG_W; k++) begin : g_f
      AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_vec[i][k]) |-> $past(wr_en && addr == ADDR_W'(i*16 + 5))); // R7
    end
  end
endmodule

bind cmt_timer_bank cmt_timer_bank_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .addr     (addr),
  .run_q    (run_q),
  .irq      (irq),
  .cnt_vec  (cnt_vec),
  .rate_vec (rate_vec),
  .stat_vec (stat_vec)
);

// File: tb/cmt_timer_bank_test.sv
`timescale 1ns/1ps
module cmt_timer_bank_test;
  localparam int NCH = 3;
  localparam int AW  = 6;
  localparam logic [AW-1:0] START = 6'd48;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [NCH-1:0]   irq;
  logic [2*NCH-1:0] cmp_pin;
  logic [7:0]    sreg = '0;
  int n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  cmt_timer_bank #(.NCH(NCH), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .cmp_pin(cmp_pin)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  task automatic rd16(input int a, output logic [15:0] v);
    logic [7:0] h, l;
    rd(a, h);
    rd(a + 1, l);
    v = {h, l};
  endtask

  task automatic set16(input int a, input logic [15:0] v);
    wr(a, v[15:8]);
    wr(a + 1, v[7:0]);
  endtask

  task automatic run_ticks(input int ch, input int clocks);
    sreg = sreg | 8'(1 << ch);
    wr(START, sreg);
    repeat (clocks - 2) @(negedge clk);
    sreg = sreg & ~8'(1 << ch);
    wr(START, sreg);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(0, v);      chk("R1", "ctrl ch0", v, 0);
    rd(16 + 5, v); chk("R1", "status ch1", v, 0);
    rd(START, v);  chk("R1", "start reg", v, 0);
    chk("R1", "irq", irq, 0);
    chk("R1", "pins", cmp_pin, 0);
  endtask

  task automatic t_rates();
    logic [15:0] c;
    wr(0, 8'h00); set16(6, 0); run_ticks(0, 7);
    rd16(6, c); chk("R3", "rate0 7 clocks", c, 7);
    wr(0, 8'h01); set16(6, 0); run_ticks(0, 10);
    rd16(6, c); chk("R3", "rate/4 10 clocks", c, 2);
    wr(0, 8'h02); set16(6, 0); run_ticks(0, 40);
    rd16(6, c); chk("R3", "rate/16 40 clocks", c, 2);
    wr(0, 8'h03); set16(6, 0); run_ticks(0, 130);
    rd16(6, c); chk("R3", "rate/64 130 clocks", c, 2);
    wr(0, 8'h05); set16(6, 16'h0055); run_ticks(0, 20);
    rd16(6, c); chk("R3", "reserved rate holds", c, 16'h0055);
  endtask

  task automatic t_clear();
    logic [15:0] c;
    logic [7:0] s;
    set16(8, 4); set16(10, 2); set16(12, 6); set16(14, 3);
    wr(0, 8'h20); set16(6, 0); run_ticks(0, 12);
    rd16(6, c); chk("R4", "clear on A period 5", c, 2);
    rd(5, s);   chk("R6", "flag A set", s[0], 1);
    wr(0, 8'h40); set16(6, 0); run_ticks(0, 10);
    rd16(6, c); chk("R4", "clear on B period 3", c, 1);
    wr(0, 8'hA0); set16(6, 0); run_ticks(0, 9);
    rd16(6, c); chk("R4", "clear on C period 7", c, 2);
    wr(0, 8'hC0); set16(6, 0); run_ticks(0, 9);
    rd16(6, c); chk("R4", "clear on D period 4", c, 1);
    wr(0, 8'h60); set16(6, 0); run_ticks(0, 9);
    rd16(6, c); chk("R4", "code 3 no clear", c, 9);
  endtask

  task automatic t_overflow();
    logic [15:0] c;
    logic [7:0] s;
    rd(16 + 5, s); chk("R5", "no overflow before wrap", s[4], 0);
    wr(16, 8'h00); set16(16 + 6, 16'hFFFE); run_ticks(1, 3);
    rd16(16 + 6, c); chk("R5", "count after wrap", c, 1);
    rd(16 + 5, s);   chk("R5", "overflow flag", s[4], 1);
  endtask

  task automatic t_status();
    logic [7:0] s;
    wr(32, 8'h00); set16(32 + 8, 1); set16(32 + 6, 0); run_ticks(2, 3);
    wr(32 + 5, 8'h00);
    rd(32 + 5, s); chk("R7", "write 0 without read keeps flag", s[0], 1);
    wr(32 + 5, 8'h3F);
    rd(32 + 5, s); chk("R7", "write 1 keeps flag", s[0], 1);
    wr(32 + 5, 8'h3E);
    rd(32 + 5, s); chk("R7", "read then write 0 clears", s[0], 0);
  endtask

  task automatic t_irq();
    logic [7:0] s;
    wr(16, 8'h00); wr(16 + 4, 8'h00);
    rd(16 + 5, s); wr(16 + 5, 8'h00);
    set16(16 + 8, 3); set16(16 + 6, 2); wr(16 + 4, 8'h01);
    sreg = sreg | 8'h02; wr(START, sreg);
    @(negedge clk); chk("R9", "irq low first tick", irq[1], 0);
    @(negedge clk); chk("R9", "irq low in flag cycle", irq[1], 0);
    @(negedge clk); chk("R9", "irq one clock after flag", irq[1], 1);
    sreg = sreg & ~8'h02; wr(START, sreg);
    rd(16 + 5, s); wr(16 + 5, 8'h00); wr(16 + 4, 8'h00);
    set16(16 + 6, 2); run_ticks(1, 4);
    repeat (2) @(negedge clk);
    chk("R9", "masked flag keeps irq low", irq[1], 0);
    wr(16 + 4, 8'h01);
    @(negedge clk); chk("R9", "enable raises irq", irq[1], 1);
  endtask

  task automatic t_pins();
    logic [7:0] v;
    wr(2, 8'h53);
    chk("R8", "pin A initial 0", cmp_pin[0], 0);
    chk("R8", "pin B initial 1", cmp_pin[1], 1);
    set16(8, 2); set16(10, 1); wr(0, 8'h20); set16(6, 0); run_ticks(0, 9);
    chk("R8", "pin A toggled three times", cmp_pin[0], 1);
    chk("R8", "pin B cleared on B", cmp_pin[1], 0);
    wr(2, 8'h00);
    chk("R8", "code 0 retains pin A", cmp_pin[0], 1);
    chk("R8", "code 0 retains pin B", cmp_pin[1], 0);
    rd(2, v); chk("R8", "pin codes readback", v, 0);
  endtask

  task automatic t_access();
    logic [15:0] c;
    logic [7:0] v;
    wr(16, 8'h07); set16(16 + 6, 16'h1234);
    rd(16 + 6, v); chk("R10", "counter high byte at 6", v, 8'h12);
    rd(16 + 7, v); chk("R10", "counter low byte at 7", v, 8'h34);
    sreg = sreg | 8'h02; wr(START, sreg);
    rd(START, v); chk("R2", "start reg readback", v, 8'h02);
    wr(16 + 6, 8'h00);
    sreg = sreg & ~8'h02; wr(START, sreg);
    rd16(16 + 6, c); chk("R10", "counter write ignored while running", c, 16'h1234);
    wr(16 + 6, 8'h00);
    rd16(16 + 6, c); chk("R10", "counter write while stopped", c, 16'h0034);
    set16(32 + 14, 16'hA5C3);
    rd(32 + 14, v); chk("R10", "compare D high at 14", v, 8'hA5);
    rd(32 + 15, v); chk("R10", "compare D low at 15", v, 8'hC3);
    wr(0, 8'h00); set16(6, 16'h0010); wr(32, 8'h00); run_ticks(2, 6);
    rd16(6, c); chk("R2", "idle channel holds while other runs", c, 16'h0010);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_rates();
    t_clear();
    t_overflow();
    t_status();
    t_irq();
    t_pins();
    t_access();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule